// File: doc/BRIEF.md
# Indexed Plug-and-Play Configuration Register File

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two byte-wide I/O ports at a base address and at the address after it. A byte written to the lower port (the index port) picks one of 256 configuration registers. The upper port (the data port) then reads or writes the register that was picked.

Registers below 0x30 are common to the whole controller. Register 0x07 holds the number of the logical device that is in view. Registers 0x30 and above form a separate bank for each logical device. Each bank holds an 8-bit function enable, a 16-bit I/O base, two IRQ selections and two DMA channel selections. The base register has read-only zero bits, set by a mask parameter. The IRQ type registers always report edge triggering.

All of this is guarded by a key. While the block is locked, data-port writes and index updates are dropped. The host unlocks it with a two-byte key written to the index port and locks it again with a one-byte key. The settings of every logical device are presented continuously on flat output buses, together with the selected device number.

Top module: `pnp_cfg_space`

## Requirements
- R1: The index port is at `BASE_ADDR` (default 0x002E) and the data port is at `BASE_ADDR+1`. A read strobe at any address other than the data port returns 0x00 on `io_rdata`, and writes to other addresses change nothing.
- R2: After reset the block is locked. The index, the selected device, all enables, bases, IRQ numbers and DMA channels are zero.
- R3: The block unlocks when 0x87 is written to the index port twice in a row. Any other value written to the index port between the two key bytes cancels the partial key.
- R4: While unlocked, writing 0xAA to the index port locks the block and leaves the index register unchanged.
- R5: While locked, data-port reads return 0xFF, data-port writes have no effect, and non-key index writes do not change the index.
- R6: Writing register 0x07 sets the selected logical device. That value is shown on `cur_ldn` and reads back from 0x07.
- R7: Register 0x30 of the selected device is its 8-bit enable. Device d drives `dev_en[8d+7:8d]`, and each device keeps its own value.
- R8: Registers 0x60 (high byte) and 0x61 (low byte) form the 16-bit I/O base. Bits that are zero in `BASE_MASK` (default 0x07F8) are forced to zero on write. Writing all ones therefore reads back the mask.
- R9: Registers 0x70 and 0x72 take IRQ numbers 0 to 15, where 0 means disabled. A write above 15 leaves the register unchanged. Registers 0x71 and 0x73 always read 0x00, which means edge type, and ignore writes.
- R10: Registers 0x74 and 0x75 store bits [2:0] as DMA channels and read back zero-extended.
- R11: When the selected device number is `NDEV` (default 4) or above, reads of 0x30 and above return 0x00 and writes there change no device.
- R12: Global registers other than 0x07, and unused banked addresses, read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_wr | input | 1 | Write strobe, one write per cycle high |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational |
| dev_en | output | 8*NDEV | Enable byte of each device |
| dev_base | output | 16*NDEV | I/O base of each device |
| dev_irq0 | output | 4*NDEV | First IRQ number of each device |
| dev_irq1 | output | 4*NDEV | Second IRQ number of each device |
| dev_dma0 | output | 3*NDEV | First DMA channel of each device |
| dev_dma1 | output | 3*NDEV | Second DMA channel of each device |
| cur_ldn | output | 8 | Selected logical device number |

## Verification
The device number is swept across every valid bank and one invalid bank. Each bank gets a distinct pattern, so a write that leaks into the wrong bank shows up on the flat outputs. An invalid device number must read zero and disturb nothing. The IRQ registers are swept over all values from 0 to 31 in both directions, which separates stored values from rejected ones. Writing all ones to the base exposes the mask, while a per-device pattern exposes byte order. The key logic is exercised with an interrupted key, a complete key and a relock. Each case shows whether the index register and the bank contents survive while locked.

// File: rtl/pnp_cfg_space.sv
module pnp_cfg_space #(
  parameter logic [15:0] BASE_ADDR  = 16'h002E,
  parameter int          NDEV       = 4,
  parameter logic [15:0] BASE_MASK  = 16'h07F8,
  parameter logic [7:0]  KEY_UNLOCK = 8'h87,
  parameter logic [7:0]  KEY_LOCK   = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic [7:0]        io_rdata,
  output logic [8*NDEV-1:0] dev_en,
  output logic [16*NDEV-1:0] dev_base,
  output logic [4*NDEV-1:0] dev_irq0,
  output logic [4*NDEV-1:0] dev_irq1,
  output logic [3*NDEV-1:0] dev_dma0,
  output logic [3*NDEV-1:0] dev_dma1,
  output logic [7:0]        cur_ldn
);
  localparam int LW = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic       unlocked_q, key_half_q;
  logic [7:0] idx_q, ldn_q;

  logic [7:0]  en_q   [NDEV];
  logic [15:0] base_q [NDEV];
  logic [3:0]  irq0_q [NDEV];
  logic [3:0]  irq1_q [NDEV];
  logic [2:0]  dma0_q [NDEV];
  logic [2:0]  dma1_q [NDEV];

  wire idx_hit  = (io_addr == BASE_ADDR);
  wire data_hit = (io_addr == BASE_ADDR + 16'd1);
  wire idx_wr   = io_wr && idx_hit;
  wire dat_wr   = io_wr && data_hit && unlocked_q;
  wire ldn_ok   = (32'(ldn_q) < NDEV);
  wire banked   = (idx_q >= 8'h30);
  wire bank_wr  = dat_wr && ldn_ok && banked;
  wire [LW-1:0] sel = ldn_q[LW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked_q <= 1'b0;
      key_half_q <= 1'b0;
      idx_q      <= 8'h00;
      ldn_q      <= 8'h00;
    end else if (idx_wr) begin
      if (unlocked_q) begin
        key_half_q <= 1'b0;
        if (io_wdata == KEY_LOCK) unlocked_q <= 1'b0;
        else                      idx_q      <= io_wdata;
      end else if (io_wdata == KEY_UNLOCK) begin
        key_half_q <= ~key_half_q;
        if (key_half_q) unlocked_q <= 1'b1;
      end else begin
        key_half_q <= 1'b0;
      end
    end else if (dat_wr && idx_q == 8'h07) begin
      ldn_q <= io_wdata;
    end
  end

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    wire hit = bank_wr && (sel == LW'(d));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[d]   <= '0;
        base_q[d] <= '0;
        irq0_q[d] <= '0;
        irq1_q[d] <= '0;
        dma0_q[d] <= '0;
        dma1_q[d] <= '0;
      end else if (hit) begin
        case (idx_q)
          8'h30: en_q[d]         <= io_wdata;
          8'h60: base_q[d][15:8] <= io_wdata & BASE_MASK[15:8];
          8'h61: base_q[d][7:0]  <= io_wdata & BASE_MASK[7:0];
          8'h70: if (io_wdata < 8'd16) irq0_q[d] <= io_wdata[3:0];
          8'h72: if (io_wdata < 8'd16) irq1_q[d] <= io_wdata[3:0];
          8'h74: dma0_q[d] <= io_wdata[2:0];
          8'h75: dma1_q[d] <= io_wdata[2:0];
          default: ;
        endcase
      end
    end
    assign dev_en[8*d +: 8]    = en_q[d];
    assign dev_base[16*d +: 16] = base_q[d];
    assign dev_irq0[4*d +: 4]  = irq0_q[d];
    assign dev_irq1[4*d +: 4]  = irq1_q[d];
    assign dev_dma0[3*d +: 3]  = dma0_q[d];
    assign dev_dma1[3*d +: 3]  = dma1_q[d];
  end

  logic [7:0] rd_val;
  always_comb begin
    rd_val = 8'h00;
    if (!unlocked_q)           rd_val = 8'hFF;
    else if (idx_q == 8'h07)   rd_val = ldn_q;
    else if (banked && ldn_ok) begin
      case (idx_q)
        8'h30: rd_val = en_q[sel];
        8'h60: rd_val = base_q[sel][15:8];
        8'h61: rd_val = base_q[sel][7:0];
        8'h70: rd_val = {4'h0, irq0_q[sel]};
        8'h72: rd_val = {4'h0, irq1_q[sel]};
        8'h74: rd_val = {5'h00, dma0_q[sel]};
        8'h75: rd_val = {5'h00, dma1_q[sel]};
        default: rd_val = 8'h00;
      endcase
    end
  end

  assign io_rdata = (io_rd && data_hit) ? rd_val : 8'h00;
  assign cur_ldn  = ldn_q;
endmodule

// File: rtl/pnp_cfg_space_chk.sv
module pnp_cfg_space_chk #(
  parameter logic [15:0] BASE_ADDR = 16'h002E,
  parameter int          NDEV      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [15:0]        io_addr,
  input logic [7:0]         io_wdata,
  input logic               io_wr,
  input logic               io_rd,
  input logic [7:0]         io_rdata,
  input logic               unlocked_q,
  input logic [7:0]         idx_q,
  input logic [7:0]         ldn_q,
  input logic [8*NDEV-1:0]  dev_en,
  input logic [16*NDEV-1:0] dev_base,
  input logic [4*NDEV-1:0]  dev_irq0,
  input logic [7:0]         cur_ldn
);
  wire dport = (io_addr == BASE_ADDR + 16'd1);
  wire iport = (io_addr == BASE_ADDR);

  p_other_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && !dport |-> io_rdata == 8'h00);

  p_unlock_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> $past(io_wr && iport && io_wdata == 8'h87));

  p_lock_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_q && io_wr && iport && io_wdata == 8'hAA |=> !unlocked_q && $stable(idx_q));

  p_locked_reads_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q && io_rd && dport |-> io_rdata == 8'hFF);

  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q && io_wr && dport |=> $stable(dev_en) && $stable(dev_base) && $stable(cur_ldn));

  p_irq_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_q && io_wr && dport && idx_q == 8'h70 && io_wdata > 8'd15 |=> $stable(dev_irq0));

  p_bad_ldn_r11: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked_q && io_wr && dport && idx_q >= 8'h30 && 32'(ldn_q) >= NDEV
    |=> $stable(dev_en) && $stable(dev_base) && $stable(dev_irq0));
endmodule

bind pnp_cfg_space pnp_cfg_space_chk #(.BASE_ADDR(BASE_ADDR), .NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata),
  .unlocked_q(unlocked_q), .idx_q(idx_q), .ldn_q(ldn_q),
  .dev_en(dev_en), .dev_base(dev_base), .dev_irq0(dev_irq0), .cur_ldn(cur_ldn)
);

// File: tb/pnp_cfg_space_tb.sv
module pnp_cfg_space_tb;
  localparam int ND = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_rdata, cur_ldn;
  logic [8*ND-1:0]  dev_en;
  logic [16*ND-1:0] dev_base;
  logic [4*ND-1:0]  dev_irq0, dev_irq1;
  logic [3*ND-1:0]  dev_dma0, dev_dma1;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  pnp_cfg_space u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] v);
    @(negedge clk); io_addr = a; io_wdata = v; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #5 v = io_rdata; io_rd = 1'b0;
  endtask

  task automatic wreg(logic [7:0] i, logic [7:0] v);
    wr(16'h002E, i); wr(16'h002F, v);
  endtask

  task automatic rreg(logic [7:0] i, output logic [7:0] v);
    wr(16'h002E, i); rd(16'h002F, v);
  endtask

  logic [7:0]  e_en  [ND];
  logic [15:0] e_base[ND];
  logic [2:0]  e_d0  [ND];
  logic [2:0]  e_d1  [ND];

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [3:0] ei;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R2 en", dev_en, 0); check("R2 base", dev_base, 0);
    check("R2 irq", {dev_irq0, dev_irq1}, 0); check("R2 dma", {dev_dma0, dev_dma1}, 0);
    check("R2 ldn", cur_ldn, 0);
    rd(16'h002F, v); check("R5 locked read", v, 8'hFF);
    wr(16'h002E, 8'h07); wr(16'h002F, 8'h03);
    check("R5 locked write", cur_ldn, 0);

    wr(16'h002E, 8'h87); wr(16'h002E, 8'h12); wr(16'h002E, 8'h87);
    rd(16'h002F, v); check("R3 broken key", v, 8'hFF);
    wr(16'h002E, 8'h12);
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    rd(16'h002F, v); check("R3 unlocked idx0", v, 8'h00);

    wreg(8'h07, 8'h02); check("R6 cur_ldn", cur_ldn, 2);
    rreg(8'h07, v); check("R6 readback", v, 2);

    for (int d = 0; d <= ND; d++) begin
      logic [7:0] hi, lo, en;
      en = 8'h5A ^ 8'(d * 8'h23);
      hi = 8'(d * 8'h13 + 8'h01);
      lo = 8'hC7 ^ 8'(d);
      wreg(8'h07, 8'(d));
      wreg(8'h30, en);
      wreg(8'h60, 8'hFF); wreg(8'h61, 8'hFF);
      rreg(8'h60, v); check("R8 mask hi", v, d < ND ? 8'h07 : 8'h00);
      rreg(8'h61, v); check("R8 mask lo", v, d < ND ? 8'hF8 : 8'h00);
      wreg(8'h60, hi); wreg(8'h61, lo);
      wreg(8'h74, 8'(d + 5)); wreg(8'hF8, 8'h00); wreg(8'h75, 8'hF8 | 8'(d));
      if (d < ND) begin
        e_en[d] = en; e_base[d] = {hi, lo} & 16'h07F8;
        e_d0[d] = 3'(d + 5); e_d1[d] = 3'(d);
      end else begin
        rreg(8'h30, v); check("R11 bad ldn read", v, 0);
        rreg(8'h74, v); check("R11 bad ldn dma", v, 0);
      end
    end
    for (int d = 0; d < ND; d++) begin
      check("R7 en out", dev_en[8*d +: 8], e_en[d]);
      check("R8 base out", dev_base[16*d +: 16], e_base[d]);
      check("R10 dma0 out", dev_dma0[3*d +: 3], e_d0[d]);
      check("R10 dma1 out", dev_dma1[3*d +: 3], e_d1[d]);
      wreg(8'h07, 8'(d));
      rreg(8'h30, v); check("R7 en read", v, e_en[d]);
      rreg(8'h60, v); check("R8 base hi", v, e_base[d][15:8]);
      rreg(8'h61, v); check("R8 base lo", v, e_base[d][7:0]);
      rreg(8'h75, v); check("R10 dma read", v, {5'h0, e_d1[d]});
      rreg(8'hF8, v); check("R12 unused banked", v, 0);
    end

    wreg(8'h07, 8'h01);
    ei = 0;
    for (int i = 0; i < 32; i++) begin
      wreg(8'h70, 8'(i));
      if (i < 16) ei = 4'(i);
      rreg(8'h70, v); check("R9 irq0 read", v, {4'h0, ei});
      check("R9 irq0 out", dev_irq0[7:4], ei);
    end
    ei = 0;
    for (int i = 31; i >= 0; i--) begin
      wreg(8'h72, 8'(i));
      if (i < 16) ei = 4'(i);
      check("R9 irq1 out", dev_irq1[7:4], ei);
    end
    check("R9 other dev irq", {dev_irq0[3:0], dev_irq1[15:8]}, 0);
    rreg(8'h71, v); check("R9 type0", v, 0);
    wreg(8'h73, 8'hFF); rreg(8'h73, v); check("R9 type1", v, 0);

    rreg(8'h20, v); check("R12 global", v, 0);
    wreg(8'h2A, 8'h55); rreg(8'h2A, v); check("R12 global wr", v, 0);

    rd(16'h002E, v); check("R1 index read", v, 0);
    wr(16'h002E, 8'h30); wr(16'h004F, 8'h00);
    check("R1 other port wr", dev_en[15:8], e_en[1]);
    rd(16'h004F, v); check("R1 other port rd", v, 0);

    wr(16'h002E, 8'hAA);
    rd(16'h002F, v); check("R4 relocked", v, 8'hFF);
    wr(16'h002F, 8'h00); check("R5 locked data wr", dev_en[15:8], e_en[1]);
    wr(16'h002E, 8'h61);
    wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
    rd(16'h002F, v); check("R4 R5 index kept", v, e_en[1]);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule